// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block steps a phase-locked loop from "settings checked" to "running and locked". A start pulse launches the run. First the core regulator is confirmed: it must be enabled with its output reported good, and the block switches it on and waits when it is not. Next the block checks the chosen reference clock. That reference must already be running, and its power class must satisfy the class the loop asks for.

Once both checks pass, the block opens the loop's control register for writing and sends the trim unlock key. It then works out a lock-wait count from the reference frequency and loads that count. After that it turns on the loop's clock and power. The stop-mode keep-alive is turned on only when the loop must run at all times. The block then waits for lock and looks at the error flag. It closes the control register again only when lock is clean.

Every start ends in exactly one done pulse with a status code. The analog loop and its bandwidth settings are not part of this block. A bring-up controller, or firmware acting through a thin wrapper, uses the block as part of clock-tree setup.

Top module: `pll_bringup_seq`

## Requirements
- R1: At start, if `ldo_en_i` and `ldo_good_i` are not both high, `ldo_en_o` goes high and nothing else happens until `ldo_good_i` is seen. If both are already high, `ldo_en_o` stays low and the run goes on at once.
- R2: If `ldo_good_i` does not arrive within `LDO_WAIT_MAX` cycles, the run ends with status 1 (regulator fail), and the control register is never opened.
- R3: `src_sel` picks bit `src_sel` of `src_active`. An index of `NSRC` or above counts as inactive. An inactive source ends the run with status 2, before any key write.
- R4: If `req_always_on` is 1 and bit `src_sel` of `src_always_on` is 0, the source's power class is too low and the run ends with status 3.
- R5: The write order is fixed. First `csr_unlock_o` rises. Next comes a one-cycle `trim_key_wr_o` pulse, during which `trim_key_o` = 16'h5A5A and `trim_unlock_o` = 1. Then comes a one-cycle `lock_time_wr_o` pulse. All of this happens while `pll_clk_en_o` is still low.
- R6: `lock_time_o` = ceil(Fref / 2000) + 300. Fref = floor(`fin_hz` / `n_div`) when `use_prediv` = 1, and Fref = `fin_hz` otherwise, in which case `n_div` is ignored.
- R7: `pll_clk_en_o` and `pll_pwr_en_o` rise in the same cycle. `pll_stop_en_o` rises with them only when `req_always_on` = 1.
- R8: If `pll_lock_i` is seen together with `pll_err_i`, the run ends with status 4.
- R9: If `pll_lock_i` is still absent 2 × `lock_time_o` cycles after the enables rise, the run ends with status 5. A lock that arrives before that bound succeeds.
- R10: On a clean lock, `csr_unlock_o` drops and the run ends with status 0. The PLL enables stay high.
- R11: Each accepted start gives exactly one one-cycle `done_o` pulse, with `status_o` valid during that cycle. A start that arrives while `busy_o` is high is ignored. Every error end drops the PLL enables and `csr_unlock_o`.
- R12: After a synchronous reset, every output is low and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (reference-rate) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| ldo_en_i | input | 1 | Regulator enabled readback |
| ldo_good_i | input | 1 | Regulator output-good |
| src_sel | input | SEL_W | Reference index |
| src_active | input | NSRC | Per-source running flag |
| src_always_on | input | NSRC | Per-source "runs in every power mode" flag |
| req_always_on | input | 1 | Loop must run in every power mode |
| fin_hz | input | FIN_W | Reference frequency in Hz |
| use_prediv | input | 1 | Pre-divider in use |
| n_div | input | N_W | Pre-divider ratio |
| pll_lock_i | input | 1 | Loop lock valid |
| pll_err_i | input | 1 | Loop error flag |
| ldo_en_o | output | 1 | Regulator enable |
| csr_unlock_o | output | 1 | Control register write-open |
| trim_key_wr_o | output | 1 | Trim key write strobe |
| trim_key_o | output | 16 | Trim key value |
| trim_unlock_o | output | 1 | Trim unlock indication |
| lock_time_wr_o | output | 1 | Lock-time write strobe |
| lock_time_o | output | LT_W | Lock-wait count |
| pll_clk_en_o | output | 1 | Loop clock enable |
| pll_pwr_en_o | output | 1 | Loop power enable |
| pll_stop_en_o | output | 1 | Stop-mode keep-alive |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | End-of-run pulse |
| status_o | output | 3 | Result code |

## Verification
The bench first targets the lock-time arithmetic. It picks one reference frequency whose quotient by 2000 leaves a remainder and one that divides evenly. A design that truncates instead of rounding up, or that forgets the startup margin, shows the wrong count. It also gives a non-unit pre-divider while the pre-divider is off; a design that applies it anyway gives a count that is too small.

The bench watches the order of events from outside the block. It checks that the key is written only while the register is open, that the count is loaded before the enables rise, and that an already-good regulator is left alone. It probes the timeout window on both sides: a lock that arrives just inside twice the count must succeed, and a lock that never arrives must fail within a few cycles of that bound. An off-by-one or a single-count window would break one of these two cases.

Finally, each error path is checked for two things: the enables must be dropped and the register closed. A second start during a run must not produce a second done pulse.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_OK       = 3'd0,
    ST_LDO_FAIL = 3'd1,
    ST_SRC_OFF  = 3'd2,
    ST_PWR_LOW  = 3'd3,
    ST_PLL_ERR  = 3'd4,
    ST_TIMEOUT  = 3'd5
  } seq_status_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LDO_CHK,
    S_LDO_WAIT,
    S_SRC_CHK,
    S_KEY,
    S_DIV_REF,
    S_DIV_LOCK,
    S_ENABLE,
    S_LOCK_WAIT,
    S_RELOCK
  } seq_state_e;

endpackage

// File: rtl/pll_seq_divider.sv
// Radix-2 restoring divider, one quotient bit per cycle.
module pll_seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  dvs;
  logic          busy;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {remainder, quotient[W-1]};
  assign fits  = trial >= {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      cnt       <= '0;
      quotient  <= '0;
      remainder <= '0;
      dvs       <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        cnt       <= CW'(W);
        quotient  <= dividend;
        remainder <= '0;
        dvs       <= divisor;
      end else if (busy) begin
        if (fits) begin
          remainder <= W'(trial - {1'b0, dvs});
          quotient  <= {quotient[W-2:0], 1'b1};
        end else begin
          remainder <= trial[W-1:0];
          quotient  <= {quotient[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: a finished division always leaves a remainder below the divisor
  a_r6_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
    done |-> (remainder < dvs));

endmodule

// File: rtl/pll_seq_lockwatch.sv
// Counts cycles spent waiting for lock; expires at twice the lock count.
module pll_seq_lockwatch #(
  parameter int LT_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm,
  input  logic            run,
  input  logic [LT_W-1:0] lock_time,
  output logic            expired
);
  logic [LT_W:0] limit;
  logic [LT_W:0] cnt;

  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit <= '0;
      cnt   <= '0;
    end else if (arm) begin
      limit <= {lock_time, 1'b0};
      cnt   <= '0;
    end else if (run && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: the wait counter never runs past its window
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= limit));

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int NSRC         = 3,
  parameter int SEL_W        = 2,
  parameter int FIN_W        = 32,
  parameter int N_W          = 8,
  parameter int LT_W         = 20,
  parameter int LOCK_DIV     = 2000,
  parameter int LOCK_MARGIN  = 300,
  parameter int LDO_WAIT_MAX = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ldo_en_i,
  input  logic             ldo_good_i,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [NSRC-1:0]  src_active,
  input  logic [NSRC-1:0]  src_always_on,
  input  logic             req_always_on,
  input  logic [FIN_W-1:0] fin_hz,
  input  logic             use_prediv,
  input  logic [N_W-1:0]   n_div,
  input  logic             pll_lock_i,
  input  logic             pll_err_i,
  output logic             ldo_en_o,
  output logic             csr_unlock_o,
  output logic             trim_key_wr_o,
  output logic [15:0]      trim_key_o,
  output logic             trim_unlock_o,
  output logic             lock_time_wr_o,
  output logic [LT_W-1:0]  lock_time_o,
  output logic             pll_clk_en_o,
  output logic             pll_pwr_en_o,
  output logic             pll_stop_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       status_o
);
  localparam logic [15:0] TRIM_KEY = 16'h5A5A;
  localparam int          PAD_N    = 1 << SEL_W;
  localparam int          LC_W     = $clog2(LDO_WAIT_MAX + 1);

  seq_state_e        state;
  logic [LC_W-1:0]   ldo_cnt;
  logic              div_start, div_done;
  logic [FIN_W-1:0]  div_dvd, div_dvs, div_q, div_r;
  logic [FIN_W-1:0]  lt_sum;
  logic [PAD_N-1:0]  act_pad, aon_pad;
  logic              src_ok, pwr_low;
  logic              wd_arm, wd_run, wd_expired;
  logic              fail_now;
  seq_status_e       fail_code;

  // Out-of-range selections read zero padding, hence "inactive".
  assign act_pad = PAD_N'(src_active);
  assign aon_pad = PAD_N'(src_always_on);
  assign src_ok  = act_pad[src_sel];
  assign pwr_low = req_always_on && !aon_pad[src_sel];

  assign lt_sum  = div_q + FIN_W'(div_r != '0) + FIN_W'(LOCK_MARGIN);

  assign wd_arm  = (state == S_ENABLE);
  assign wd_run  = (state == S_LOCK_WAIT);

  pll_seq_divider #(.W(FIN_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .start     (div_start),
    .dividend  (div_dvd),
    .divisor   (div_dvs),
    .done      (div_done),
    .quotient  (div_q),
    .remainder (div_r)
  );

  pll_seq_lockwatch #(.LT_W(LT_W)) u_watch (
    .clk       (clk),
    .rst       (rst),
    .arm       (wd_arm),
    .run       (wd_run),
    .lock_time (lock_time_o),
    .expired   (wd_expired)
  );

  always_comb begin
    fail_now  = 1'b0;
    fail_code = ST_OK;
    case (state)
      S_LDO_WAIT: if (!ldo_good_i && ldo_cnt == LC_W'(LDO_WAIT_MAX - 1)) begin
        fail_now  = 1'b1;
        fail_code = ST_LDO_FAIL;
      end
      S_SRC_CHK: if (!src_ok) begin
        fail_now  = 1'b1;
        fail_code = ST_SRC_OFF;
      end else if (pwr_low) begin
        fail_now  = 1'b1;
        fail_code = ST_PWR_LOW;
      end
      S_LOCK_WAIT: if (pll_lock_i && pll_err_i) begin
        fail_now  = 1'b1;
        fail_code = ST_PLL_ERR;
      end else if (!pll_lock_i && wd_expired) begin
        fail_now  = 1'b1;
        fail_code = ST_TIMEOUT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= S_IDLE;
      ldo_cnt        <= '0;
      div_start      <= 1'b0;
      div_dvd        <= '0;
      div_dvs        <= '0;
      ldo_en_o       <= 1'b0;
      csr_unlock_o   <= 1'b0;
      trim_key_wr_o  <= 1'b0;
      trim_key_o     <= '0;
      trim_unlock_o  <= 1'b0;
      lock_time_wr_o <= 1'b0;
      lock_time_o    <= '0;
      pll_clk_en_o   <= 1'b0;
      pll_pwr_en_o   <= 1'b0;
      pll_stop_en_o  <= 1'b0;
      busy_o         <= 1'b0;
      done_o         <= 1'b0;
      status_o       <= 3'd0;
    end else begin
      done_o         <= 1'b0;
      div_start      <= 1'b0;
      trim_key_wr_o  <= 1'b0;
      trim_unlock_o  <= 1'b0;
      lock_time_wr_o <= 1'b0;
      if (fail_now) begin
        state         <= S_IDLE;
        done_o        <= 1'b1;
        status_o      <= fail_code;
        busy_o        <= 1'b0;
        csr_unlock_o  <= 1'b0;
        pll_clk_en_o  <= 1'b0;
        pll_pwr_en_o  <= 1'b0;
        pll_stop_en_o <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            busy_o <= 1'b1;
            state  <= S_LDO_CHK;
          end
          S_LDO_CHK: begin
            if (ldo_en_i && ldo_good_i) begin
              state <= S_SRC_CHK;
            end else begin
              ldo_en_o <= 1'b1;
              ldo_cnt  <= '0;
              state    <= S_LDO_WAIT;
            end
          end
          S_LDO_WAIT: begin
            if (ldo_good_i) state <= S_SRC_CHK;
            else            ldo_cnt <= ldo_cnt + 1'b1;
          end
          S_SRC_CHK: begin
            csr_unlock_o <= 1'b1;
            state        <= S_KEY;
          end
          S_KEY: begin
            trim_key_wr_o <= 1'b1;
            trim_key_o    <= TRIM_KEY;
            trim_unlock_o <= 1'b1;
            div_dvd       <= fin_hz;
            div_dvs       <= use_prediv ? FIN_W'(n_div) : FIN_W'(1);
            div_start     <= 1'b1;
            state         <= S_DIV_REF;
          end
          S_DIV_REF: if (div_done) begin
            div_dvd   <= div_q;
            div_dvs   <= FIN_W'(LOCK_DIV);
            div_start <= 1'b1;
            state     <= S_DIV_LOCK;
          end
          S_DIV_LOCK: if (div_done) begin
            lock_time_o    <= lt_sum[LT_W-1:0];
            lock_time_wr_o <= 1'b1;
            state          <= S_ENABLE;
          end
          S_ENABLE: begin
            pll_clk_en_o  <= 1'b1;
            pll_pwr_en_o  <= 1'b1;
            pll_stop_en_o <= req_always_on;
            state         <= S_LOCK_WAIT;
          end
          S_LOCK_WAIT: if (pll_lock_i) state <= S_RELOCK;
          S_RELOCK: begin
            csr_unlock_o <= 1'b0;
            done_o       <= 1'b1;
            status_o     <= ST_OK;
            busy_o       <= 1'b0;
            state        <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R11: done is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R11: error ends leave the loop off and the register closed
  a_r11_err_off: assert property (@(posedge clk) disable iff (rst)
    (done_o && status_o != 3'd0) |-> (!pll_clk_en_o && !csr_unlock_o));
  // R5: key only goes out while the register is open
  a_r5_key_while_open: assert property (@(posedge clk) disable iff (rst)
    trim_key_wr_o |-> (csr_unlock_o && trim_key_o == TRIM_KEY));
  // R5: lock count is loaded before the loop is enabled
  a_r5_count_before_enable: assert property (@(posedge clk) disable iff (rst)
    lock_time_wr_o |-> !pll_clk_en_o);
  // R6: loaded count always includes the startup margin
  a_r6_margin_present: assert property (@(posedge clk) disable iff (rst)
    lock_time_wr_o |-> (lock_time_o >= LT_W'(LOCK_MARGIN)));
  // R7: clock and power enables move together
  a_r7_enable_pair: assert property (@(posedge clk) disable iff (rst)
    pll_clk_en_o == pll_pwr_en_o);
  // R7: keep-alive never on without the loop clock
  a_r7_stop_needs_clk: assert property (@(posedge clk) disable iff (rst)
    pll_stop_en_o |-> pll_clk_en_o);
  // R1: the register opens only after the regulator reported good
  a_r1_ldo_first: assert property (@(posedge clk) disable iff (rst)
    $rose(csr_unlock_o) |-> $past(ldo_good_i));
  // R10: a clean end closes the register and keeps the loop running
  a_r10_ok_relocked: assert property (@(posedge clk) disable iff (rst)
    (done_o && status_o == 3'd0) |-> (!csr_unlock_o && pll_clk_en_o));

endmodule

// File: tb/pll_bringup_seq_test.sv
module pll_bringup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ldo_en_i = 1'b0, ldo_good_i = 1'b0;
  logic [1:0]  src_sel = '0;
  logic [2:0]  src_active = '0, src_always_on = '0;
  logic        req_always_on = 1'b0;
  logic [31:0] fin_hz = '0;
  logic        use_prediv = 1'b0;
  logic [7:0]  n_div = 8'd1;
  logic        pll_lock_i = 1'b0, pll_err_i = 1'b0;
  logic        ldo_en_o, csr_unlock_o, trim_key_wr_o, trim_unlock_o;
  logic [15:0] trim_key_o;
  logic        lock_time_wr_o;
  logic [19:0] lock_time_o;
  logic        pll_clk_en_o, pll_pwr_en_o, pll_stop_en_o, busy_o, done_o;
  logic [2:0]  status_o;

  pll_bringup_seq uut (
    .clk(clk), .rst(rst), .start(start), .ldo_en_i(ldo_en_i), .ldo_good_i(ldo_good_i),
    .src_sel(src_sel), .src_active(src_active), .src_always_on(src_always_on),
    .req_always_on(req_always_on), .fin_hz(fin_hz), .use_prediv(use_prediv),
    .n_div(n_div), .pll_lock_i(pll_lock_i), .pll_err_i(pll_err_i),
    .ldo_en_o(ldo_en_o), .csr_unlock_o(csr_unlock_o), .trim_key_wr_o(trim_key_wr_o),
    .trim_key_o(trim_key_o), .trim_unlock_o(trim_unlock_o),
    .lock_time_wr_o(lock_time_wr_o), .lock_time_o(lock_time_o),
    .pll_clk_en_o(pll_clk_en_o), .pll_pwr_en_o(pll_pwr_en_o),
    .pll_stop_en_o(pll_stop_en_o), .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  // environment models
  logic ldo_pre = 1'b0;
  int   ldo_delay = 0, ldo_cnt = 0;
  int   lock_delay = 10, pll_cnt = 0;
  logic err_on_lock = 1'b0;
  // observations
  int   key_seen, lt_seen, done_cnt, en_cyc, done_cyc, lt_val;
  logic key_ok, lt_clk, en_seen, en_pwr, en_stop, unl_seen, unl_good;
  logic [2:0] done_stat;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (trim_key_wr_o) begin
      key_seen++;
      key_ok = (trim_key_o == 16'h5A5A) && trim_unlock_o && csr_unlock_o;
    end
    if (lock_time_wr_o) begin lt_seen++; lt_val = int'(lock_time_o); lt_clk = pll_clk_en_o; end
    if (pll_clk_en_o && !en_seen) begin
      en_seen = 1'b1; en_cyc = cyc; en_pwr = pll_pwr_en_o; en_stop = pll_stop_en_o;
    end
    if (csr_unlock_o && !unl_seen) begin unl_seen = 1'b1; unl_good = ldo_good_i; end
    if (done_o) begin done_cnt++; done_cyc = cyc; done_stat = status_o; end
    // regulator model
    ldo_en_i = ldo_en_o || ldo_pre;
    if (ldo_en_i) ldo_cnt++; else ldo_cnt = 0;
    ldo_good_i = ldo_en_i && (ldo_cnt > ldo_delay);
    // loop model
    if (pll_clk_en_o) pll_cnt++; else pll_cnt = 0;
    pll_lock_i = pll_clk_en_o && (pll_cnt >= lock_delay);
    pll_err_i  = pll_lock_i && err_on_lock;
    if (cyc > WD_LIMIT) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setup(input logic pre, input int ldly, input logic [1:0] sel,
                       input logic [2:0] act, input logic [2:0] aon, input logic req,
                       input int fin, input logic pd, input int n, input int ldel,
                       input logic perr);
    do_reset();
    ldo_pre = pre; ldo_delay = ldly; src_sel = sel; src_active = act;
    src_always_on = aon; req_always_on = req; fin_hz = fin; use_prediv = pd;
    n_div = 8'(n); lock_delay = ldel; err_on_lock = perr;
    key_seen = 0; lt_seen = 0; done_cnt = 0; en_cyc = 0; done_cyc = 0; lt_val = 0;
    key_ok = 0; lt_clk = 0; en_seen = 0; en_pwr = 0; en_stop = 0;
    unl_seen = 0; unl_good = 0; done_stat = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input bool_restart);
    int n = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (bool_restart) begin
      repeat (3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (done_cnt == 0 && n < 20000) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!done_o && !busy_o && !pll_clk_en_o && !csr_unlock_o && !ldo_en_o && status_o == 0,
        "R12", "outputs after reset", {done_o, busy_o, pll_clk_en_o, csr_unlock_o, ldo_en_o}, 0);
  endtask

  task automatic t_ok_prediv();
    setup(1, 0, 2'd1, 3'b111, 3'b111, 1, 12_000_000, 1, 3, 50, 0);
    run(1);
    chk(done_stat == 0, "R10", "status", done_stat, 0);
    chk(done_cnt == 1, "R11", "done pulses with restart", done_cnt, 1);
    chk(lt_val == 2300, "R6", "lock time 12M/3", lt_val, 2300);
    chk(key_seen == 1 && key_ok, "R5", "key write", key_seen, 1);
    chk(lt_seen == 1 && !lt_clk, "R5", "count before enable", lt_clk, 0);
    chk(en_pwr && en_stop, "R7", "pwr+stop with clk", {en_pwr, en_stop}, 3);
    chk(!csr_unlock_o && pll_clk_en_o, "R10", "relocked and running",
        {csr_unlock_o, pll_clk_en_o}, 1);
    chk(!ldo_en_o, "R1", "regulator untouched when good", ldo_en_o, 0);
  endtask

  task automatic t_ok_ceil();
    setup(1, 0, 2'd0, 3'b001, 3'b000, 0, 600_001, 0, 7, 20, 0);
    run(0);
    chk(done_stat == 0, "R10", "status", done_stat, 0);
    chk(lt_val == 601, "R6", "lock time round-up, prediv off", lt_val, 601);
    chk(en_pwr && !en_stop, "R7", "no keep-alive", {en_pwr, en_stop}, 2);
  endtask

  task automatic t_ldo_wait();
    setup(0, 20, 2'd2, 3'b100, 3'b100, 1, 45_000_000, 0, 1, 10, 0);
    run(0);
    chk(ldo_en_o, "R1", "regulator enabled", ldo_en_o, 1);
    chk(unl_seen && unl_good, "R1", "open only after good", unl_good, 1);
    chk(done_stat == 0 && lt_val == 22800, "R6", "lock time 45M", lt_val, 22800);
  endtask

  task automatic t_ldo_fail();
    setup(0, 100000, 2'd0, 3'b111, 3'b111, 0, 1_000_000, 0, 1, 10, 0);
    run(0);
    chk(done_stat == 1, "R2", "regulator fail status", done_stat, 1);
    chk(!unl_seen, "R2", "register never opened", unl_seen, 0);
  endtask

  task automatic t_src_off();
    setup(1, 0, 2'd1, 3'b101, 3'b111, 0, 1_000_000, 0, 1, 10, 0);
    run(0);
    chk(done_stat == 2 && key_seen == 0, "R3", "inactive source", done_stat, 2);
    setup(1, 0, 2'd3, 3'b111, 3'b111, 0, 1_000_000, 0, 1, 10, 0);
    run(0);
    chk(done_stat == 2, "R3", "out-of-range index", done_stat, 2);
  endtask

  task automatic t_pwr_low();
    setup(1, 0, 2'd0, 3'b111, 3'b110, 1, 1_000_000, 0, 1, 10, 0);
    run(0);
    chk(done_stat == 3 && !csr_unlock_o, "R4", "power class mismatch", done_stat, 3);
  endtask

  task automatic t_pll_err();
    setup(1, 0, 2'd0, 3'b111, 3'b111, 0, 1_000_000, 0, 1, 30, 1);
    run(0);
    chk(done_stat == 4, "R8", "error flag at lock", done_stat, 4);
    chk(!pll_clk_en_o && !pll_pwr_en_o && !csr_unlock_o, "R11", "error end shuts off",
        {pll_clk_en_o, pll_pwr_en_o, csr_unlock_o}, 0);
    chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
  endtask

  task automatic t_timeout();
    setup(1, 0, 2'd0, 3'b111, 3'b111, 0, 200_000, 0, 1, 780, 0);
    run(0);
    chk(done_stat == 0 && lt_val == 400, "R9", "late lock inside window", done_stat, 0);
    setup(1, 0, 2'd0, 3'b111, 3'b111, 0, 200_000, 0, 1, 1000000, 0);
    run(0);
    chk(done_stat == 5, "R9", "timeout status", done_stat, 5);
    chk(done_cyc - en_cyc >= 800 && done_cyc - en_cyc <= 804, "R9", "timeout window",
        done_cyc - en_cyc, 800);
    chk(!pll_clk_en_o, "R11", "timeout shuts off", pll_clk_en_o, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_ok_prediv();
    t_ok_ceil();
    t_ldo_wait();
    t_ldo_fail();
    t_src_off();
    t_pwr_low();
    t_pll_err();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule